// File: doc/BRIEF.md
# Triple Prescaled Interval Timer Unit

This block contains three interval timers that advance on a shared core-cycle enable. Each timer has its own fixed prescaler, an 8-bit divider and a programmable 8-bit match value. Timers 0 and 1 divide the core enable by 128, and timer 2 divides it by 16. When a timer is enabled, each prescaler expiry adds one to its divider. When the divider reaches the match value, the divider restarts at zero and a 4-bit event counter advances, wrapping after 15.

Software sees only the event counters. The bus decoder in front of the block turns register accesses into strobes. A control write carries all three enable bits together. Each timer has its own strobe for loading its match value and its own read strobe. A read strobe returns the counter's present value on `cnt_o` and clears the counter in the same cycle. A typical use is pacing a sound or sequencing routine that polls a counter and acts on the number of periods elapsed since its last read.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every counter reads 0, every match value is 0 and every timer is disabled, so the counters stay at 0 while core enables arrive.
- R2: Every prescaler counts only in cycles where `tick_i` is high. It expires on the first such cycle after reset and after that once every 128 such cycles for timers 0 and 1, and once every 16 for timer 2. It keeps counting while its timer is disabled.
- R3: Each prescaler expiry adds one to the divider of an enabled timer. When the incremented divider equals the match value, the divider returns to 0 and the counter increments. A timer with match value P therefore counts once every P expiries.
- R4: A match value of 0 lets the divider run through all 256 values before it matches, which gives one count every 256 expiries.
- R5: The counter is 4 bits wide and wraps from 15 to 0.
- R6: A control write that sets a timer's enable bit while that timer is disabled clears its divider and its counter.
- R7: A control write that sets an enable bit that is already set leaves the divider and counter of that timer untouched.
- R8: While a timer is disabled, its divider and counter hold their values.
- R9: A read strobe clears the addressed counter on the next edge. Before that edge `cnt_o` shows the value being read. Other timers are not affected.
- R10: If a read strobe and a counter increment land in the same cycle, the counter ends at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Core-cycle enable that advances all prescalers |
| en_we_i | input | 1 | Control write strobe for the enable bits |
| en_d_i | input | 3 | Enable bits, bit i for timer i |
| tgt_we_i | input | 3 | Match value load strobe, bit i for timer i |
| tgt_d_i | input | 8 | Match value to load |
| rd_i | input | 3 | Read-and-clear strobe, bit i for timer i |
| cnt_o | output | 12 | Counter values, timer i on bits [4i+3:4i] |

## Verification
Nothing inside the block is visible except the counters, so a wrong prescaler phase or divider value appears only as a counter that advances early or late. With timers 0 and 1, that difference can take up to 128 core enables per divider step to show up. For this reason the bench runs every case long enough to cover several full periods and compares the final counts against closed-form arithmetic on the number of expiries. A divider that is not cleared when its timer is enabled is exposed by choosing a run length at which a stale divider and a cleared divider give different counts. Read-clear and same-cycle collisions act on `cnt_o` at the very next edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NUM_TMR  = 3;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned CNT_W    = 4;
  localparam int unsigned PRE_SLOW = 128;
  localparam int unsigned PRE_FAST = 16;
  localparam int unsigned FAST_IDX = 2;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned LEN = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic fire_o
);
  localparam int unsigned PW = (LEN > 2) ? $clog2(LEN) : 1;

  logic [PW-1:0] pre_q;

  assign fire_o = tick_i && (pre_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_i) pre_q <= (pre_q == '0) ? PW'(LEN - 1) : pre_q - 1'b1;
  end

  // R2: idle without core enable, reload on expiry
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pre_q));
  a_r2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> pre_q == PW'(LEN - 1));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             en_we_i,
  input  logic             en_d_i,
  input  logic             tgt_we_i,
  input  logic [DIV_W-1:0] tgt_d_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic             en_q;
  logic [DIV_W-1:0] tgt_q, div_q, div_inc;
  logic [CNT_W-1:0] cnt_q;
  logic             rise, adv, hit;

  assign rise    = en_we_i && en_d_i && !en_q;
  assign adv     = fire_i && en_q;
  assign div_inc = div_q + 1'b1;     // wraps, so target 0 waits 256 steps
  assign hit     = (div_inc == tgt_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      tgt_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (en_we_i)  en_q  <= en_d_i;
      if (tgt_we_i) tgt_q <= tgt_d_i;
      if (rise) begin
        div_q <= '0;
        cnt_q <= '0;
      end else begin
        if (adv)            div_q <= hit ? '0 : div_inc;
        if (rd_i)           cnt_q <= '0;
        else if (adv && hit) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r6_rise_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (cnt_q == '0) && (div_q == '0));
  a_r7_rewrite_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_we_i && en_d_i && en_q && !fire_i && !rd_i) |=> $stable(cnt_q) && $stable(div_q));
  a_r8_disabled_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !rise) |=> $stable(div_q));
  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> cnt_q == '0);
  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !rise) |=> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned N_TMR  = NUM_TMR,
  parameter int unsigned D_W    = DIV_W,
  parameter int unsigned C_W    = CNT_W,
  parameter int unsigned P_SLOW = PRE_SLOW,
  parameter int unsigned P_FAST = PRE_FAST,
  parameter int unsigned F_IDX  = FAST_IDX
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               en_we_i,
  input  logic [N_TMR-1:0]   en_d_i,
  input  logic [N_TMR-1:0]   tgt_we_i,
  input  logic [D_W-1:0]     tgt_d_i,
  input  logic [N_TMR-1:0]   rd_i,
  output logic [N_TMR*C_W-1:0] cnt_o
);
  logic [N_TMR-1:0] fire;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    localparam int unsigned LEN = (g == F_IDX) ? P_FAST : P_SLOW;

    tmr_prescale #(.LEN(LEN)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .fire_o (fire[g])
    );

    tmr_chan #(.DIV_W(D_W), .CNT_W(C_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fire_i   (fire[g]),
      .en_we_i  (en_we_i),
      .en_d_i   (en_d_i[g]),
      .tgt_we_i (tgt_we_i[g]),
      .tgt_d_i  (tgt_d_i),
      .rd_i     (rd_i[g]),
      .cnt_o    (cnt_o[g*C_W +: C_W])
    );
  end

  // R2: no expiry without core enable
  a_r2_fire_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> fire == '0);
endmodule

// File: tb/tri_interval_timer_tb_top.sv
module tri_interval_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        en_we_i = 1'b0;
  logic [2:0]  en_d_i = '0;
  logic [2:0]  tgt_we_i = '0;
  logic [7:0]  tgt_d_i = '0;
  logic [2:0]  rd_i = '0;
  logic [11:0] cnt_o;

  int errors = 0;
  int checks = 0;
  int tk = 0;

  always #10 clk_i = ~clk_i;

  tri_interval_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .en_we_i(en_we_i),
    .en_d_i(en_d_i), .tgt_we_i(tgt_we_i), .tgt_d_i(tgt_d_i), .rd_i(rd_i),
    .cnt_o(cnt_o)
  );

  function automatic int plen(int i);
    return (i == 2) ? 16 : 128;
  endfunction

  // expiries at tick indices k in [a,b) with k % n == 0
  function automatic int ev(int n, int a, int b);
    return (b + n - 1) / n - (a + n - 1) / n;
  endfunction

  function automatic int peff(int p);
    return (p == 0) ? 256 : p;
  endfunction

  task automatic check(string tag, int idx, int exp);
    int got;
    got = int'(cnt_o[idx*4 +: 4]);
    checks++;
    if (got != (exp % 16)) begin
      errors++;
      $display("FAIL %s timer%0d: got %0d expected %0d", tag, idx, got, exp % 16);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    tick_i = 1'b0; en_we_i = 1'b0; tgt_we_i = '0; rd_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    tk = 0;
  endtask

  task automatic run(int m);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (m) @(negedge clk_i);
    tick_i = 1'b0;
    tk += m;
  endtask

  task automatic wr_tgt(logic [2:0] mask, int v);
    @(negedge clk_i);
    tgt_we_i = mask; tgt_d_i = 8'(v);
    @(negedge clk_i);
    tgt_we_i = '0;
  endtask

  task automatic wr_en(logic [2:0] bits);
    @(negedge clk_i);
    en_we_i = 1'b1; en_d_i = bits;
    @(negedge clk_i);
    en_we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] mask);
    @(negedge clk_i);
    rd_i = mask;
    @(negedge clk_i);
    rd_i = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int sweep[6] = '{1, 2, 3, 5, 7, 200};
    int base[3];
    int rd_ev;
    do_reset();
    for (int i = 0; i < 3; i++) check("R1 reset", i, 0);
    run(300);
    for (int i = 0; i < 3; i++) check("R1 disabled after reset", i, 0);

    // R3/R5 sweep: distinct match values per timer
    foreach (sweep[s]) begin
      do_reset();
      for (int i = 0; i < 3; i++) wr_tgt(3'(1 << i), sweep[s] + i);
      wr_en(3'b111);
      run(1000);
      for (int i = 0; i < 3; i++)
        check("R3 R5 sweep", i, ev(plen(i), 0, 1000) / peff(sweep[s] + i));
    end

    // R4: match value 0, with wrap on timer 2
    do_reset();
    wr_tgt(3'b111, 0);
    wr_en(3'b111);
    run(69632);
    for (int i = 0; i < 3; i++) check("R4 target zero", i, ev(plen(i), 0, 69632) / 256);

    // R2: prescaler keeps its phase while disabled
    do_reset();
    wr_tgt(3'b100, 1);
    run(100);
    check("R8 disabled", 2, 0);
    wr_en(3'b100);
    run(60);
    check("R2 phase kept", 2, ev(16, 100, 160));
    check("R2 other disabled", 0, 0);

    // R9: read clears only the addressed timer
    do_reset();
    wr_tgt(3'b111, 3);
    wr_en(3'b111);
    run(1000);
    check("R2 slow period", 0, ev(128, 0, 1000) / 3);
    rd(3'b001);
    check("R9 read cleared", 0, 0);
    check("R9 neighbour kept", 1, ev(128, 0, 1000) / 3);
    check("R9 neighbour kept", 2, ev(16, 0, 1000) / 3);
    rd_ev = ev(128, 0, 1000);
    run(500);
    check("R9 continues", 0, ev(128, 0, 1500) / 3 - rd_ev / 3);
    check("R3 unread", 1, ev(128, 0, 1500) / 3);

    // R7: rewriting set enables changes nothing
    wr_en(3'b111);
    run(500);
    check("R7 rewrite", 0, ev(128, 0, 2000) / 3 - rd_ev / 3);
    check("R7 rewrite", 1, ev(128, 0, 2000) / 3);
    check("R7 rewrite", 2, ev(16, 0, 2000) / 3);
    base[0] = ev(128, 0, 2000) / 3 - rd_ev / 3;
    base[1] = ev(128, 0, 2000) / 3;
    base[2] = ev(16, 0, 2000) / 3;

    // R8: disabled timers hold
    wr_en(3'b000);
    run(300);
    for (int i = 0; i < 3; i++) check("R8 hold", i, base[i]);

    // R6: enable rise clears counter and divider
    wr_en(3'b001);
    check("R6 counter cleared", 0, 0);
    check("R8 still held", 1, base[1]);
    run(256);
    check("R6 divider cleared", 0, ev(128, 2300, 2556) / 3);

    // R10: read collides with increment
    do_reset();
    wr_tgt(3'b100, 1);
    wr_en(3'b100);
    @(negedge clk_i);
    tick_i = 1'b1; rd_i = 3'b100;
    @(negedge clk_i);
    tick_i = 1'b0; rd_i = '0;
    tk = 1;
    check("R10 collision", 2, 0);
    run(15);
    check("R10 no early step", 2, 0);
    run(1);
    check("R2 fast period", 2, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule